// File: doc/BRIEF.md
# Extended Instruction Length and Operand Address Decoder

This block takes one instruction, already fetched as four bytes, and works out everything the execution stage needs before it touches memory. It reports the length of the instruction (1, 2, 3 or 4 bytes), the opcode, the two register fields of the register-to-register form, and the addressing mode. From the flag bits it builds either a 20-bit target address or an immediate operand. Alongside the instruction it receives the address of that instruction and the low 20 bits of the base (B) and index (X) registers. It also flags indirect references, for which the consumer performs one more memory read to fetch the final address, and it flags mode combinations that are illegal.

Instructions enter on a valid/ready stream and results leave on a second valid/ready stream through a single output register. An input transfer happens on a clock edge where `in_valid` and `in_ready` are both high. An output transfer happens where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so the block can sustain one instruction per clock. While the consumer stalls, the result is held unchanged. A producer must keep `in_valid` and its data steady until the transfer takes place.

Bit numbering of the input word `in_bytes`: the first byte is `[31:24]`. The flags follow it: n=`[25]`, i=`[24]`, x=`[23]`, b=`[22]`, p=`[21]`, e=`[20]`. The short displacement is `[19:8]` and the long address is `[19:0]`.

Top module: `xd_decoder`

## Requirements
- R1: `out_len` gives the byte count. It is 1 when the upper nibble of the first byte is 0xC or 0xF, and 2 when that nibble is 0x9, 0xA or 0xB. Otherwise it is 4 when e=1 and at least one of n, i is set, and 3 in every remaining case.
- R2: For lengths 1 and 2, `out_mode` is 0 (none), the target and all three flags are 0, and no memory is referenced. For length 2, `out_r1`=`in_bytes[23:20]` and `out_r2`=`in_bytes[19:16]`; for length 1 both are 0.
- R3: With b=1 and p=0 (e=0), the mode is 2 (base) and the target is B plus the 12-bit displacement taken as unsigned, modulo 2^20.
- R4: With b=0 and p=1 (e=0), the mode is 3 (PC-relative) and the target is the instruction address plus `out_len` plus the displacement taken as signed 12-bit, modulo 2^20.
- R5: With b=0, p=0 and e=0, the mode is 1 (direct) and the target is the displacement. In every non-illegal memory form, x=1 adds X to the target, modulo 2^20.
- R6: With e=1 (and n or i set), the mode is 1 and the target is the 20-bit field `[19:0]`. If b or p is also set, the result is illegal as in R10.
- R7: When n=0 and i=1, `out_imm`=1 and `out_mem_ref`=0, and `out_target` carries the value computed as in R3 to R6, to be used as the operand.
- R8: When n=1 and i=0, `out_ind`=1 and `out_mem_ref`=1, and `out_target` is the address of the word that holds the final address.
- R9: When n=0 and i=0 (standard form), the mode is 4 (legacy) and the length is 3 even if e=1. The target is the 15-bit value `in_bytes[22:8]` (b, p and e become address bits), plus X when x=1.
- R10: When b=1 and p=1, the mode is 5 (illegal), the target is 0, and `out_imm`, `out_ind` and `out_mem_ref` are 0.
- R11: The stream rules above hold: `in_ready` equals `!out_valid || out_ready`, and a stalled result stays unchanged. Every accepted instruction produces exactly one result, in order.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1.
- R13: `out_opcode` is the first byte with its two low bits cleared for lengths 3 and 4, and the whole first byte for lengths 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Decoder can take an instruction |
| in_bytes | input | 32 | Instruction bytes, first byte in [31:24] |
| in_pc | input | ADDR_W | Address of the instruction |
| in_base | input | ADDR_W | Low bits of the base register B |
| in_index | input | ADDR_W | Low bits of the index register X |
| out_valid | output | 1 | Decoded result present |
| out_ready | input | 1 | Consumer takes the result |
| out_len | output | 3 | Instruction length in bytes |
| out_opcode | output | 8 | Opcode |
| out_r1 | output | 4 | First register field |
| out_r2 | output | 4 | Second register field |
| out_mode | output | 3 | 0 none, 1 direct, 2 base, 3 PC-relative, 4 legacy, 5 illegal |
| out_target | output | ADDR_W | Target address or immediate value |
| out_imm | output | 1 | Target is an immediate operand |
| out_ind | output | 1 | Target points to the final address |
| out_mem_ref | output | 1 | A memory operand is referenced |

## Verification
The two functions that meet in one cycle are draining a held result and accepting the next instruction. The bench drives `out_ready` and `in_valid` at random, so stalls, back-to-back transfers and simultaneous drain-and-fill all occur. In that combined cycle the new decode must land in the output register without losing or duplicating the one leaving. Each cycle, a queue-based model predicts the front result and the value of `in_ready`, and these are compared against the ports. Directed words cover every mode, both wrap-arounds and the illegal forms; random words cover the rest.

// File: rtl/xd_pkg.sv
package xd_pkg;
  localparam int INSN_W  = 32;
  localparam int SDISP_W = 12;
  localparam int LADDR_W = 20;
  localparam int LEG_W   = 15;

  typedef enum logic [2:0] {
    MODE_NONE    = 3'd0,
    MODE_DIRECT  = 3'd1,
    MODE_BASE    = 3'd2,
    MODE_PCREL   = 3'd3,
    MODE_LEGACY  = 3'd4,
    MODE_ILLEGAL = 3'd5
  } xd_mode_e;

  typedef struct packed {
    logic n;
    logic i;
    logic x;
    logic b;
    logic p;
    logic e;
  } xd_flags_t;
endpackage

// File: rtl/xd_len_detect.sv
module xd_len_detect (
  input  logic [3:0] op_hi,
  input  logic [1:0] ni,
  input  logic       e_bit,
  output logic [2:0] len,
  output logic       reg_form,
  output logic       legacy
);
  logic one_byte, two_byte;

  always_comb begin
    one_byte = (op_hi == 4'hC) || (op_hi == 4'hF);
    two_byte = (op_hi >= 4'h9) && (op_hi <= 4'hB);
    reg_form = one_byte || two_byte;
    legacy   = !reg_form && (ni == 2'b00);
    if (one_byte)               len = 3'd1;
    else if (two_byte)          len = 3'd2;
    else if (legacy || !e_bit)  len = 3'd3;
    else                        len = 3'd4;
  end
endmodule

// File: rtl/xd_flag_decode.sv
module xd_flag_decode
  import xd_pkg::*;
(
  input  xd_flags_t fl,
  input  logic      reg_form,
  input  logic      legacy,
  output xd_mode_e  mode,
  output logic      imm,
  output logic      ind,
  output logic      idx_en,
  output logic      mem_ref
);
  logic bad;

  always_comb begin
    bad = !reg_form && !legacy &&
          ((fl.b && fl.p) || (fl.e && (fl.b || fl.p)));
    if (reg_form)     mode = MODE_NONE;
    else if (legacy)  mode = MODE_LEGACY;
    else if (bad)     mode = MODE_ILLEGAL;
    else if (fl.b)    mode = MODE_BASE;
    else if (fl.p)    mode = MODE_PCREL;
    else              mode = MODE_DIRECT;

    imm     = !reg_form && !legacy && !bad && !fl.n && fl.i;
    ind     = !reg_form && !legacy && !bad && fl.n && !fl.i;
    idx_en  = !reg_form && !bad && fl.x;
    mem_ref = !reg_form && !bad && !imm;
  end
endmodule

// File: rtl/xd_addr_calc.sv
module xd_addr_calc
  import xd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  xd_mode_e            mode,
  input  logic                long_form,
  input  logic [SDISP_W-1:0]  disp,
  input  logic [LADDR_W-1:0]  long_addr,
  input  logic [LEG_W-1:0]    leg_addr,
  input  logic [2:0]          len,
  input  logic [ADDR_W-1:0]   pc,
  input  logic [ADDR_W-1:0]   base,
  input  logic [ADDR_W-1:0]   index,
  input  logic                idx_en,
  output logic [ADDR_W-1:0]   target
);
  localparam int SX_W = ADDR_W - SDISP_W;

  logic [ADDR_W-1:0] disp_u, disp_s, long_u, leg_u, raw;

  generate
    if (SX_W > 0) begin : g_ext
      assign disp_u = {{SX_W{1'b0}}, disp};
      assign disp_s = {{SX_W{disp[SDISP_W-1]}}, disp};
    end else begin : g_trunc
      assign disp_u = disp[ADDR_W-1:0];
      assign disp_s = disp[ADDR_W-1:0];
    end
  endgenerate

  assign long_u = ADDR_W'(long_addr);
  assign leg_u  = ADDR_W'(leg_addr);

  always_comb begin
    case (mode)
      MODE_BASE:   raw = base + disp_u;
      MODE_PCREL:  raw = pc + ADDR_W'(len) + disp_s;
      MODE_DIRECT: raw = long_form ? long_u : disp_u;
      MODE_LEGACY: raw = leg_u;
      default:     raw = '0;
    endcase
    target = idx_en ? raw + index : raw;
  end
endmodule

// File: rtl/xd_decoder.sv
module xd_decoder
  import xd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_bytes,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic [ADDR_W-1:0] in_base,
  input  logic [ADDR_W-1:0] in_index,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_len,
  output logic [7:0]        out_opcode,
  output logic [3:0]        out_r1,
  output logic [3:0]        out_r2,
  output logic [2:0]        out_mode,
  output logic [ADDR_W-1:0] out_target,
  output logic              out_imm,
  output logic              out_ind,
  output logic              out_mem_ref
);
  xd_flags_t         fl;
  logic [2:0]        len_c;
  logic              reg_form, legacy;
  xd_mode_e          mode_c;
  logic              imm_c, ind_c, idx_en, mem_c;
  logic [ADDR_W-1:0] tgt_c;
  logic [7:0]        op_c;
  logic [3:0]        r1_c, r2_c;
  logic              take;

  assign fl = '{n: in_bytes[25], i: in_bytes[24], x: in_bytes[23],
                b: in_bytes[22], p: in_bytes[21], e: in_bytes[20]};

  xd_len_detect u_len (
    .op_hi    (in_bytes[31:28]),
    .ni       (in_bytes[25:24]),
    .e_bit    (in_bytes[20]),
    .len      (len_c),
    .reg_form (reg_form),
    .legacy   (legacy)
  );

  xd_flag_decode u_flags (
    .fl       (fl),
    .reg_form (reg_form),
    .legacy   (legacy),
    .mode     (mode_c),
    .imm      (imm_c),
    .ind      (ind_c),
    .idx_en   (idx_en),
    .mem_ref  (mem_c)
  );

  xd_addr_calc #(.ADDR_W(ADDR_W)) u_addr (
    .mode      (mode_c),
    .long_form (fl.e),
    .disp      (in_bytes[19:8]),
    .long_addr (in_bytes[19:0]),
    .leg_addr  (in_bytes[22:8]),
    .len       (len_c),
    .pc        (in_pc),
    .base      (in_base),
    .index     (in_index),
    .idx_en    (idx_en),
    .target    (tgt_c)
  );

  always_comb begin
    op_c = reg_form ? in_bytes[31:24] : {in_bytes[31:26], 2'b00};
    r1_c = (len_c == 3'd2) ? in_bytes[23:20] : 4'h0;
    r2_c = (len_c == 3'd2) ? in_bytes[19:16] : 4'h0;
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_len     <= '0;
      out_opcode  <= '0;
      out_r1      <= '0;
      out_r2      <= '0;
      out_mode    <= '0;
      out_target  <= '0;
      out_imm     <= 1'b0;
      out_ind     <= 1'b0;
      out_mem_ref <= 1'b0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take) begin
        out_len     <= len_c;
        out_opcode  <= op_c;
        out_r1      <= r1_c;
        out_r2      <= r2_c;
        out_mode    <= mode_c;
        out_target  <= tgt_c;
        out_imm     <= imm_c;
        out_ind     <= ind_c;
        out_mem_ref <= mem_c;
      end
    end
  end
endmodule

// File: rtl/xd_decoder_chk.sv
module xd_decoder_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [2:0]        out_len,
  input logic [2:0]        out_mode,
  input logic [ADDR_W-1:0] out_target,
  input logic              out_imm,
  input logic              out_ind,
  input logic              out_mem_ref
);
  p_len_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len >= 3'd1 && out_len <= 3'd4));

  p_reg_form_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_len <= 3'd2) |-> (out_mode == 3'd0 && !out_mem_ref && out_target == '0));

  p_imm_nomem_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_imm) |-> (!out_mem_ref && !out_ind));

  p_ind_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ind) |-> out_mem_ref);

  p_legacy_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mode == 3'd4) |-> (out_len == 3'd3 && !out_imm && !out_ind));

  p_illegal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mode == 3'd5) |-> (out_target == '0 && !out_mem_ref && !out_imm && !out_ind));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_target) && $stable(out_mode) && $stable(out_len)));

  p_fill_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_reset_r12: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind xd_decoder xd_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_len(out_len),
  .out_mode(out_mode), .out_target(out_target), .out_imm(out_imm),
  .out_ind(out_ind), .out_mem_ref(out_mem_ref)
);

// File: tb/tb_xd_decoder.sv
module tb_xd_decoder;
  localparam int AW    = 20;
  localparam int NDIR  = 14;
  localparam int NTOT  = 600;
  localparam int MASK  = 32'h000FFFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [31:0]   in_bytes = '0;
  logic [AW-1:0] in_pc = '0, in_base = '0, in_index = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [2:0]    out_len;
  logic [7:0]    out_opcode;
  logic [3:0]    out_r1, out_r2;
  logic [2:0]    out_mode;
  logic [AW-1:0] out_target;
  logic          out_imm, out_ind, out_mem_ref;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  typedef struct {
    int len; int op; int r1; int r2; int mode; int tgt;
    int imm; int ind; int mem; string tag;
  } exp_t;

  exp_t q[$];

  always #10 clk = ~clk;

  xd_decoder #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bytes(in_bytes), .in_pc(in_pc), .in_base(in_base), .in_index(in_index),
    .out_valid(out_valid), .out_ready(out_ready), .out_len(out_len),
    .out_opcode(out_opcode), .out_r1(out_r1), .out_r2(out_r2),
    .out_mode(out_mode), .out_target(out_target), .out_imm(out_imm),
    .out_ind(out_ind), .out_mem_ref(out_mem_ref)
  );

  task automatic chk(string tag, string what, int act, int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(logic [31:0] w, int pc, int b, int x);
    exp_t e;
    int hi = int'(w[31:28]);
    int n = int'(w[25]), i = int'(w[24]), xb = int'(w[23]);
    int bb = int'(w[22]), pb = int'(w[21]), eb = int'(w[20]);
    int disp = int'(w[19:8]);
    int sd = (disp >= 2048) ? disp - 4096 : disp;
    int t = 0;
    e.len = 0; e.op = 0; e.r1 = 0; e.r2 = 0; e.mode = 0; e.tgt = 0;
    e.imm = 0; e.ind = 0; e.mem = 0; e.tag = "R2";
    if (hi == 12 || hi == 15) begin
      e.len = 1; e.op = int'(w[31:24]);
    end else if (hi >= 9 && hi <= 11) begin
      e.len = 2; e.op = int'(w[31:24]);
      e.r1 = int'(w[23:20]); e.r2 = int'(w[19:16]);
    end else begin
      e.op = int'(w[31:24]) & 32'hFC;
      if (n == 0 && i == 0) begin
        e.len = 3; e.mode = 4; e.tag = "R9"; e.mem = 1;
        t = int'(w[22:8]);
        if (xb != 0) t = t + x;
        e.tgt = t & MASK;
      end else begin
        e.len = (eb != 0) ? 4 : 3;
        if ((bb != 0 && pb != 0) || (eb != 0 && (bb != 0 || pb != 0))) begin
          e.mode = 5; e.tag = "R10";
        end else begin
          if (eb != 0)      begin t = int'(w[19:0]);     e.mode = 1; e.tag = "R6"; end
          else if (bb != 0) begin t = b + disp;          e.mode = 2; e.tag = "R3"; end
          else if (pb != 0) begin t = pc + e.len + sd;   e.mode = 3; e.tag = "R4"; end
          else              begin t = disp;              e.mode = 1; e.tag = "R5"; end
          if (xb != 0) t = t + x;
          e.tgt = t & MASK;
          e.imm = (n == 0 && i == 1) ? 1 : 0;
          e.ind = (n == 1 && i == 0) ? 1 : 0;
          e.mem = (e.imm != 0) ? 0 : 1;
          if (e.imm != 0) e.tag = "R7";
          else if (e.ind != 0) e.tag = "R8";
        end
      end
    end
    return e;
  endfunction

  task automatic load_vec(int k);
    in_pc = '0; in_base = '0; in_index = '0;
    case (k)
      0:  in_bytes = 32'hC4000000;
      1:  in_bytes = 32'h9C350000;
      2:  begin in_bytes = 32'h034FFF00; in_base = 20'hFFF00; end
      3:  begin in_bytes = 32'h03280000; in_pc = 20'h00100; end
      4:  begin in_bytes = 32'h03812300; in_index = 20'h00010; end
      5:  in_bytes = 32'h031ABCDE;
      6:  in_bytes = 32'h03312345;
      7:  in_bytes = 32'h01000500;
      8:  begin in_bytes = 32'h02201000; in_pc = 20'h00200; end
      9:  begin in_bytes = 32'h0097AB00; in_index = 20'h00003; end
      10: in_bytes = 32'h03600000;
      11: begin in_bytes = 32'h01912345; in_index = 20'h00005; end
      12: begin in_bytes = 32'h032FFF00; in_pc = 20'hFFFFE; end
      13: in_bytes = 32'hF8AB0000;
      default: begin
        in_bytes = $urandom();
        in_pc    = AW'($urandom());
        in_base  = AW'($urandom());
        in_index = AW'($urandom());
      end
    endcase
  endtask

  task automatic compare_out();
    exp_t e;
    if (out_valid) begin
      if (q.size() == 0) begin
        chk("R11", "result without input", 1, 0);
      end else begin
        e = q[0];
        chk("R1", "len", int'(out_len), e.len);
        chk("R13", "opcode", int'(out_opcode), e.op);
        chk("R2", "r1", int'(out_r1), e.r1);
        chk("R2", "r2", int'(out_r2), e.r2);
        chk(e.tag, "mode", int'(out_mode), e.mode);
        chk(e.tag, "target", int'(out_target), e.tgt);
        chk(e.tag, "imm", int'(out_imm), e.imm);
        chk(e.tag, "ind", int'(out_ind), e.ind);
        chk(e.tag, "mem_ref", int'(out_mem_ref), e.mem);
      end
    end
  endtask

  initial begin : main
    int sent = 0;
    bit accepted = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "out_valid after reset", int'(out_valid), 0);
    chk("R12", "in_ready after reset", int'(in_ready), 1);
    for (int cyc = 0; cyc < 6000 && (sent < NTOT || q.size() > 0); cyc++) begin
      @(negedge clk);
      compare_out();
      out_ready = ($urandom() % 4) != 0;
      if (!in_valid || accepted) begin
        if (sent < NTOT && ($urandom() % 5) != 0) begin
          load_vec(sent);
          in_valid = 1'b1;
        end else begin
          in_valid = 1'b0;
        end
      end
      #1;
      chk("R11", "in_ready", int'(in_ready), int'(!out_valid || out_ready));
      if (out_valid && out_ready && q.size() > 0) void'(q.pop_front());
      accepted = in_valid && in_ready;
      if (accepted) begin
        q.push_back(model(in_bytes, int'(in_pc), int'(in_base), int'(in_index)));
        sent++;
      end
    end
    chk("R11", "results outstanding", q.size(), 0);
    chk("R11", "instructions sent", sent, NTOT);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL R11 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule